// File: doc/BRIEF.md
# Per-Signal Programmable Delay Bank

This block lines up five related signals in time before they enter a weighted pixel-mixing datapath: two 12-bit pixels (A and B), a 12-bit weight, a 1-bit number-format flag and a 2-bit rounding select. Each signal passes through its own delay line. The delay for each line is any whole number of main-clock cycles from 0 to 7. With a delay of zero, the output follows the input in the same cycle.

The five delay counts sit in one 15-bit configuration word. The word is written one bit at a time through a serial data line and a load strobe. The strobe is not tied to the main clock, so the block resynchronises it and performs one shift for each rising edge it detects. A bypass input drops every delay to zero at once and clears the stored word. The configuration is meant to be set up while no pixels are flowing. When a count does change, the new tap is used from the next cycle, and the block does not flush the delay lines.

Top module: `sigdelay_bank`

## Requirements
- R1: The configuration word is 15 bits wide and holds five unsigned 3-bit delay counts. Bits [2:0] set the delay of pixel A, [5:3] pixel B, [8:6] the weight, [11:9] the format flag and [14:12] the rounding select. For example, the value 0x0020 gives pixel B a delay of 4 and every other signal a delay of 0.
- R2: Each detected rising edge of `ser_strobe` shifts the word down by one place, and the sampled `ser_bit` enters at bit 14. The first bit sent therefore ends up in bit 0 after 15 edges, and the last bit sent ends up in bit 14.
- R3: When a signal's count is n, with n from 1 to 7, its output equals the value its input had n main-clock cycles earlier.
- R4: When a signal's count is 0, its output equals its input in the same cycle, with no register in the path.
- R5: While `bypass` is high, every output equals its input in the same cycle, whatever the stored word holds.
- R6: A clock edge that sees `bypass` high clears the stored word. After `bypass` falls, every delay stays at 0 until the word is reloaded.
- R7: A strobe that stays high for many cycles causes exactly one shift.
- R8: The five delay lines run independently of one another. Each line follows only its own 3-bit field.
- R9: After synchronous reset the stored word is zero, so every output equals its input.
- R10: If more than 15 bits are sent, the older bits drop out of bit 0. The word then holds the last 15 bits sent, in order.
- R11: A new count takes effect on the cycle after the word changes. The output then shows the input history at the new depth, with no flush of the delay lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial configuration data bit |
| ser_strobe | input | 1 | Load strobe; each rising edge shifts in one bit |
| bypass | input | 1 | Forces all delays to zero and clears the word |
| pix_a_in | input | 12 | Pixel A input |
| pix_b_in | input | 12 | Pixel B input |
| wgt_in | input | 12 | Weight input |
| fmt_in | input | 1 | Number-format flag input |
| rnd_in | input | 2 | Rounding select input |
| pix_a_out | output | 12 | Delayed pixel A |
| pix_b_out | output | 12 | Delayed pixel B |
| wgt_out | output | 12 | Delayed weight |
| fmt_out | output | 1 | Delayed format flag |
| rnd_out | output | 2 | Delayed rounding select |

## Verification
The bench goes after the corner cases that a plausible design error would break:
- **Field order, bit order and overflow.** It loads words whose five fields all differ, plus 18-bit streams. A design that shifts the wrong way or swaps fields would delay the wrong signal by the wrong amount, and one that keeps the oldest bits would misbehave after overflow.
- **Long strobe.** It holds the strobe high for many cycles. An edge detector replaced by a level test would shift the same bit in repeatedly and move every later field.
- **Bypass.** It checks bypass both while it is asserted and after it is released. A design that only gated the taps would bring back the old delays afterwards.
- **Extreme counts.** It runs counts of 0 and 7 and changes the word mid-stream. An off-by-one tap or a registered zero path would show the wrong history.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int NUM_CH  = 5;
    localparam int FIELD_W = 3;
    localparam int CFG_W   = NUM_CH * FIELD_W;
    localparam int MAX_DLY = (1 << FIELD_W) - 1;

    localparam int PIX_W = 12;
    localparam int WGT_W = 12;
    localparam int FMT_W = 1;
    localparam int RND_W = 2;

    // Channel order follows the field order of the configuration word.
    typedef enum int {
        CH_PIX_A = 0,
        CH_PIX_B = 1,
        CH_WGT   = 2,
        CH_FMT   = 3,
        CH_RND   = 4
    } sdb_chan_e;

    // The last member sits in the LSBs, so pixel A packs at offset 0.
    typedef struct packed {
        logic [RND_W-1:0] rnd;
        logic [FMT_W-1:0] fmt;
        logic [WGT_W-1:0] wgt;
        logic [PIX_W-1:0] pix_b;
        logic [PIX_W-1:0] pix_a;
    } sdb_bundle_t;

    localparam int BUNDLE_W = $bits(sdb_bundle_t);

    function automatic int ch_width(input int ch);
        case (ch)
            CH_PIX_A: return PIX_W;
            CH_PIX_B: return PIX_W;
            CH_WGT:   return WGT_W;
            CH_FMT:   return FMT_W;
            default:  return RND_W;
        endcase
    endfunction

    function automatic int ch_offset(input int ch);
        int acc;
        acc = 0;
        for (int k = 0; k < ch; k++) acc += ch_width(k);
        return acc;
    endfunction

endpackage

// File: rtl/sdb_cfg_loader.sv
module sdb_cfg_loader #(
    parameter int CFG_W  = 15,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    input  logic             ser_strobe,
    input  logic             bypass,
    output logic [CFG_W-1:0] cfg
);

    // Strobe and data travel through synchroniser chains of equal depth,
    // so the data bit arrives in step with its strobe edge.
    logic [SYNC_N-1:0] stb_sync;
    logic [SYNC_N-1:0] bit_sync;
    logic              stb_prev;
    logic              stb_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_sync <= '0;
            bit_sync <= '0;
            stb_prev <= 1'b0;
        end else begin
            stb_sync <= {stb_sync[SYNC_N-2:0], ser_strobe};
            bit_sync <= {bit_sync[SYNC_N-2:0], ser_bit};
            stb_prev <= stb_sync[SYNC_N-1];
        end
    end

    assign stb_rise = stb_sync[SYNC_N-1] & ~stb_prev;

    // New bits enter at the top; the first bit sent drifts down to bit 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bypass) begin
            cfg <= '0;
        end else if (stb_rise) begin
            cfg <= {bit_sync[SYNC_N-1], cfg[CFG_W-1:1]};
        end
    end

    // R2
    shift_down_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && !bypass) |=> (cfg[CFG_W-2:0] == $past(cfg[CFG_W-1:1])));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb_rise && !bypass) |=> $stable(cfg));

    // R6
    bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (cfg == '0));

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (cfg == '0));

endmodule

// File: rtl/sdb_sel_decode.sv
module sdb_sel_decode #(
    parameter int NUM_CH  = 5,
    parameter int FIELD_W = 3,
    localparam int CFG_W  = NUM_CH * FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg,
    input  logic             bypass,
    output logic [CFG_W-1:0] sel_flat
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_field
        always_comb begin
            sel_flat[c*FIELD_W +: FIELD_W] =
                bypass ? '0 : cfg[c*FIELD_W +: FIELD_W];
        end
    end

    // R5
    bypass_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (sel_flat == '0));

endmodule

// File: rtl/sdb_tap_line.sv
module sdb_tap_line #(
    parameter int W     = 12,
    parameter int DEPTH = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
    end

    // A count of zero takes the input straight through; count n picks stg[n-1].
    always_comb begin
        dout = din;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(sel) == k + 1) dout = stg[k];
        end
    end

    // R3
    first_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stg[0] == $past(din)));

    // R3
    tap_one_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((sel != SEL_W'(1)) || (dout == $past(din))));

    // R4
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (dout == din));

endmodule

// File: rtl/sigdelay_bank.sv
module sigdelay_bank
    import sdb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    input  logic             ser_strobe,
    input  logic             bypass,
    input  logic [PIX_W-1:0] pix_a_in,
    input  logic [PIX_W-1:0] pix_b_in,
    input  logic [WGT_W-1:0] wgt_in,
    input  logic [FMT_W-1:0] fmt_in,
    input  logic [RND_W-1:0] rnd_in,
    output logic [PIX_W-1:0] pix_a_out,
    output logic [PIX_W-1:0] pix_b_out,
    output logic [WGT_W-1:0] wgt_out,
    output logic [FMT_W-1:0] fmt_out,
    output logic [RND_W-1:0] rnd_out
);

    logic [CFG_W-1:0]    cfg_word;
    logic [CFG_W-1:0]    sel_flat;
    sdb_bundle_t         in_b;
    sdb_bundle_t         out_b;
    logic [BUNDLE_W-1:0] in_flat;
    logic [BUNDLE_W-1:0] out_flat;

    sdb_cfg_loader #(
        .CFG_W (CFG_W),
        .SYNC_N(SYNC_STAGES)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .ser_bit   (ser_bit),
        .ser_strobe(ser_strobe),
        .bypass    (bypass),
        .cfg       (cfg_word)
    );

    sdb_sel_decode #(
        .NUM_CH (NUM_CH),
        .FIELD_W(FIELD_W)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_word),
        .bypass  (bypass),
        .sel_flat(sel_flat)
    );

    always_comb begin
        in_b.pix_a = pix_a_in;
        in_b.pix_b = pix_b_in;
        in_b.wgt   = wgt_in;
        in_b.fmt   = fmt_in;
        in_b.rnd   = rnd_in;
    end

    assign in_flat = in_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int CW  = ch_width(c);
        localparam int OFS = ch_offset(c);

        sdb_tap_line #(
            .W    (CW),
            .DEPTH(MAX_DLY),
            .SEL_W(FIELD_W)
        ) u_line (
            .clk (clk),
            .rst (rst),
            .sel (sel_flat[c*FIELD_W +: FIELD_W]),
            .din (in_flat[OFS +: CW]),
            .dout(out_flat[OFS +: CW])
        );
    end

    assign out_b     = sdb_bundle_t'(out_flat);
    assign pix_a_out = out_b.pix_a;
    assign pix_b_out = out_b.pix_b;
    assign wgt_out   = out_b.wgt;
    assign fmt_out   = out_b.fmt;
    assign rnd_out   = out_b.rnd;

    // R5
    bypass_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> ({rnd_out, fmt_out, wgt_out, pix_b_out, pix_a_out} ==
                    {rnd_in, fmt_in, wgt_in, pix_b_in, pix_a_in}));

endmodule

// File: tb/sigdelay_bank_test.sv
`timescale 1ns/1ps
module sigdelay_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_bit = 1'b0;
    logic        ser_strobe = 1'b0;
    logic        bypass = 1'b0;
    logic [11:0] cur [5];
    logic [11:0] hist [5][8];
    logic [11:0] pix_a_out, pix_b_out, wgt_out;
    logic [0:0]  fmt_out;
    logic [1:0]  rnd_out;
    logic [14:0] m_cfg = '0;
    int          checks = 0;
    int          failures = 0;
    bit          chk_en = 1'b0;
    bit          done = 1'b0;
    string       tag = "R9";

    always #2.5 clk = ~clk;

    sigdelay_bank uut (
        .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_strobe(ser_strobe),
        .bypass(bypass),
        .pix_a_in(cur[0]), .pix_b_in(cur[1]), .wgt_in(cur[2]),
        .fmt_in(cur[3][0:0]), .rnd_in(cur[4][1:0]),
        .pix_a_out(pix_a_out), .pix_b_out(pix_b_out), .wgt_out(wgt_out),
        .fmt_out(fmt_out), .rnd_out(rnd_out)
    );

    function automatic logic [11:0] width_mask(input int c);
        case (c)
            3:       return 12'h001;
            4:       return 12'h003;
            default: return 12'hFFF;
        endcase
    endfunction

    function automatic int delay_of(input int c);
        if (bypass) return 0;
        return int'(m_cfg[c*3 +: 3]);
    endfunction

    function automatic logic [11:0] expected(input int c);
        int n;
        n = delay_of(c);
        if (n == 0) return cur[c];
        return hist[c][n-1];
    endfunction

    function automatic logic [11:0] actual(input int c);
        case (c)
            0:       return pix_a_out;
            1:       return pix_b_out;
            2:       return wgt_out;
            3:       return {11'd0, fmt_out};
            default: return {10'd0, rnd_out};
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        for (int c = 0; c < 5; c++) cur[c] = 12'($urandom) & width_mask(c);
        #1;
        if (chk_en) begin
            for (int c = 0; c < 5; c++) begin
                checks++;
                if (actual(c) !== expected(c)) begin
                    failures++;
                    $display("FAIL %s ch%0d delay=%0d actual=%h expected=%h",
                             tag, c, delay_of(c), actual(c), expected(c));
                end
            end
        end
        for (int c = 0; c < 5; c++) begin
            for (int k = 7; k > 0; k--) hist[c][k] = hist[c][k-1];
            hist[c][0] = cur[c];
        end
    endtask

    task automatic send_bit(input logic b, input int hold);
        ser_bit = b;
        ser_strobe = 1'b1;
        repeat (hold) step();
        ser_strobe = 1'b0;
        repeat (3) step();
        m_cfg = {b, m_cfg[14:1]};
    endtask

    task automatic load(input logic [14:0] v, input int long_idx);
        for (int i = 0; i < 15; i++) send_bit(v[i], (i == long_idx) ? 20 : 3);
        repeat (2) step();
    endtask

    task automatic run(input string t, input int n);
        tag = t;
        chk_en = 1'b1;
        repeat (n) step();
        chk_en = 1'b0;
    endtask

    function automatic logic [14:0] pack_fields(input int a, input int b,
                                                input int w, input int f,
                                                input int r);
        return {3'(r), 3'(f), 3'(w), 3'(b), 3'(a)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 5; c++) begin
            cur[c] = '0;
            for (int k = 0; k < 8; k++) hist[c][k] = '0;
        end
        repeat (3) step();
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int c = 0; c < 5; c++)
            for (int k = 0; k < 8; k++) hist[c][k] = '0;

        // R9: cleared word after reset, outputs follow inputs
        run("R9", 8);

        // R1: 0x0020 sets only pixel B to four stages
        load(15'h0020, -1);
        run("R1", 30);

        // R2: distinct fields reveal shift direction and bit order
        load(pack_fields(1, 2, 3, 4, 5), -1);
        run("R2", 30);

        // R3: deepest tap on every line
        load(15'h7FFF, -1);
        run("R3", 30);

        // R4: zero-count lines alongside deep ones
        load(pack_fields(0, 7, 0, 7, 0), -1);
        run("R4", 30);

        // R8: random, independent fields
        for (int i = 0; i < 5; i++) begin
            load(15'($urandom), -1);
            run("R8", 25);
        end

        // R11: reload while data flows, checked right after
        load(pack_fields(6, 1, 5, 2, 3), -1);
        run("R11", 20);

        // R7: one bit sent with a long-held strobe
        load(pack_fields(3, 5, 1, 6, 2), 5);
        run("R7", 30);

        // R10: 18 bits sent, only the last 15 kept
        for (int i = 0; i < 18; i++) send_bit(1'($urandom), 3);
        repeat (2) step();
        run("R10", 30);

        // R5: bypass overrides a non-zero word
        load(pack_fields(4, 7, 2, 3, 6), -1);
        bypass = 1'b1;
        run("R5", 20);
        m_cfg = '0;
        bypass = 1'b0;
        // R6: delays stay at zero after bypass falls
        run("R6", 20);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule